// File: doc/BRIEF.md
# Stereo DC Offset Removal Filter

This block strips the constant (DC) component from a stereo stream of 24-bit two's-complement audio samples. Each channel runs its own first-order high-pass section: the difference of the current and previous input, plus a slightly leaky copy of the previous output. The leak factor is a fixed fraction of one per sample, so the corner frequency tracks the sample rate. The corner is about 1 Hz at a 48 kHz rate and about 2 Hz at 96 kHz. The -0.1 dB point sits near 6.5 Hz at 48 kHz and scales in the same way.

A new left/right pair arrives with a one-cycle strobe. The filtered pair appears one clock later with its own one-cycle strobe. Between strobes the filter state and the outputs hold their values. A synchronous clear, intended to be driven from the power-down control, empties both channels' history, so the first sample after a clear passes through unchanged. The feedback state keeps eight fractional bits and two guard bits, and only the output is clamped to the 24-bit range.

Top module: `dc_block_hpf`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `out_valid` is 0 and both outputs are 0.
- R2: `out_valid` is high for exactly the cycle after each cycle with `in_valid` high and `clear` low, and low at all other times.
- R3: The first sample pair accepted after reset or clear is output unchanged on both channels.
- R4: For each accepted sample x, with previous accepted input xp and internal state s (signed, 8 fractional bits), the new state is s' = (x - xp)*256 + s - floor(s / 8192), and the output is floor(s'/256) clamped to the 24-bit range.
- R5: The left and right channels are filtered independently; a channel fed only zeros outputs zeros whatever the other channel carries.
- R6: After 48000 accepted samples of a constant full-scale positive input, starting from a cleared state, the output magnitude is below 131072.
- R7: The output saturates: a result above 8388607 gives 8388607, and a result below -8388608 gives -8388608. The stored state is not clamped.
- R8: A high `clear` empties both channels' history and zeros the outputs at the next edge. It overrides a strobe in the same cycle: that sample is dropped and produces no `out_valid`.
- R9: In cycles with `in_valid` low, the outputs and the filter state do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clear | input | 1 | Synchronous history clear, tied to power-down |
| in_valid | input | 1 | Sample pair strobe |
| in_left | input | 24 | Left input sample, two's complement |
| in_right | input | 24 | Right input sample, two's complement |
| out_valid | output | 1 | Filtered pair strobe, one cycle after `in_valid` |
| out_left | output | 24 | Filtered left sample |
| out_right | output | 24 | Filtered right sample |

## Verification
The hardest condition to reach from the ports is output saturation. The differentiator and the leaky feedback cancel for most inputs, so the clamp is exercised only when the stored state already sits at one full-scale rail and the input then jumps to the opposite rail. The stimulus clears the filter, loads one rail as the first sample so that the state equals it exactly, and then applies the opposite rail. It does this in both directions, on opposite channels at the same time. The slow decay under a DC input is reached by streaming one second's worth of back-to-back strobes.

// File: rtl/dcb_pkg.sv
package dcb_pkg;
  localparam int DCB_CHANNELS = 2;
  localparam int DCB_GUARD_W  = 2;
endpackage

// File: rtl/dcb_sat.sv
module dcb_sat #(
  parameter int IN_W  = 34,
  parameter int OUT_W = 24
) (
  input  logic signed [IN_W-1:0]  din,
  output logic signed [OUT_W-1:0] dout
);
  localparam int EXT_W = IN_W - OUT_W + 1;
  localparam logic signed [IN_W-1:0] MAXV = {{EXT_W{1'b0}}, {(OUT_W-1){1'b1}}};
  localparam logic signed [IN_W-1:0] MINV = {{EXT_W{1'b1}}, {(OUT_W-1){1'b0}}};

  always_comb begin
    if (din > MAXV)      dout = MAXV[OUT_W-1:0];
    else if (din < MINV) dout = MINV[OUT_W-1:0];
    else                 dout = din[OUT_W-1:0];
  end
endmodule

// File: rtl/dcb_channel.sv
module dcb_channel #(
  parameter int DATA_W = 24,
  parameter int FRAC_W = 8,
  parameter int SHIFT  = 13
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     clear,
  input  logic                     strobe,
  input  logic signed [DATA_W-1:0] x,
  output logic signed [DATA_W-1:0] y
);
  localparam int ACC_W = DATA_W + dcb_pkg::DCB_GUARD_W + FRAC_W;
  localparam int EXT_W = ACC_W - DATA_W;

  logic signed [DATA_W-1:0] x_prev;
  logic signed [ACC_W-1:0]  acc;
  logic signed [ACC_W-1:0]  x_ext, xp_ext, diff, diff_sc, leak, acc_next, acc_int;
  logic signed [DATA_W-1:0] y_sat;

  always_comb begin
    x_ext    = {{EXT_W{x[DATA_W-1]}}, x};
    xp_ext   = {{EXT_W{x_prev[DATA_W-1]}}, x_prev};
    diff     = x_ext - xp_ext;
    diff_sc  = diff <<< FRAC_W;
    leak     = acc >>> SHIFT;
    acc_next = diff_sc + acc - leak;
    acc_int  = acc_next >>> FRAC_W;
  end

  dcb_sat #(.IN_W(ACC_W), .OUT_W(DATA_W)) u_sat (
    .din  (acc_int),
    .dout (y_sat)
  );

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      x_prev <= '0;
      acc    <= '0;
      y      <= '0;
    end else if (strobe) begin
      x_prev <= x;
      acc    <= acc_next;
      y      <= y_sat;
    end
  end
endmodule

// File: rtl/dc_block_hpf.sv
module dc_block_hpf #(
  parameter int DATA_W = 24,
  parameter int FRAC_W = 8,
  parameter int SHIFT  = 13
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     clear,
  input  logic                     in_valid,
  input  logic signed [DATA_W-1:0] in_left,
  input  logic signed [DATA_W-1:0] in_right,
  output logic                     out_valid,
  output logic signed [DATA_W-1:0] out_left,
  output logic signed [DATA_W-1:0] out_right
);
  localparam int CH = dcb_pkg::DCB_CHANNELS;

  logic signed [DATA_W-1:0] ch_in  [CH];
  logic signed [DATA_W-1:0] ch_out [CH];

  assign ch_in[0]  = in_left;
  assign ch_in[1]  = in_right;
  assign out_left  = ch_out[0];
  assign out_right = ch_out[1];

  for (genvar c = 0; c < CH; c++) begin : g_ch
    dcb_channel #(.DATA_W(DATA_W), .FRAC_W(FRAC_W), .SHIFT(SHIFT)) u_ch (
      .clk    (clk),
      .rst    (rst),
      .clear  (clear),
      .strobe (in_valid),
      .x      (ch_in[c]),
      .y      (ch_out[c])
    );
  end

  always_ff @(posedge clk) begin
    if (rst || clear) out_valid <= 1'b0;
    else              out_valid <= in_valid;
  end
endmodule

// File: rtl/dcb_checker.sv
module dcb_checker #(
  parameter int DATA_W = 24
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     clear,
  input logic                     in_valid,
  input logic signed [DATA_W-1:0] in_left,
  input logic signed [DATA_W-1:0] in_right,
  input logic                     out_valid,
  input logic signed [DATA_W-1:0] out_left,
  input logic signed [DATA_W-1:0] out_right
);
  logic fresh;
  always_ff @(posedge clk) begin
    if (rst || clear) fresh <= 1'b1;
    else if (in_valid) fresh <= 1'b0;
  end

  // R2: every accepted strobe yields an output strobe next cycle
  a_r2_strobe_follows: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !clear) |=> out_valid);

  // R2: no output strobe without an accepted input strobe
  a_r2_no_spurious: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ($past(in_valid) && !$past(clear)));

  // R8: clear empties the outputs at the next edge
  a_r8_clear_zeroes: assert property (@(posedge clk) disable iff (rst)
    clear |=> (!out_valid && out_left == '0 && out_right == '0));

  // R9: outputs hold without a strobe
  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    (!in_valid && !clear) |=> ($stable(out_left) && $stable(out_right)));

  // R3: first pair after reset or clear passes unchanged
  a_r3_first_passes: assert property (@(posedge clk) disable iff (rst)
    (fresh && in_valid && !clear) |=>
      (out_left == $past(in_left) && out_right == $past(in_right)));
endmodule

bind dc_block_hpf dcb_checker #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .clear     (clear),
  .in_valid  (in_valid),
  .in_left   (in_left),
  .in_right  (in_right),
  .out_valid (out_valid),
  .out_left  (out_left),
  .out_right (out_right)
);

// File: tb/tb_dc_block_hpf.sv
module tb_dc_block_hpf;
  localparam longint PMAX = 64'sd8388607;
  localparam longint NMIN = -64'sd8388608;
  localparam int NV = 12;
  localparam logic signed [23:0] TL [NV] = '{
    24'sd1000, 24'sd1000, 24'sd1000, -24'sd5000, 24'sd0, 24'sd123456,
    -24'sd2000000, 24'sd7000000, 24'sd7000000, -24'sd1, 24'sd42, 24'sd0};
  localparam logic signed [23:0] TR [NV] = '{
    -24'sd300, 24'sd0, 24'sd65535, 24'sd65535, 24'sd65535, -24'sd8000000,
    24'sd3000000, 24'sd10, -24'sd10, 24'sd500000, 24'sd500000, 24'sd500000};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic clear = 1'b0;
  logic in_valid = 1'b0;
  logic signed [23:0] in_left = '0;
  logic signed [23:0] in_right = '0;
  logic out_valid;
  logic signed [23:0] out_left, out_right;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  longint acc_l = 0, xp_l = 0, acc_r = 0, xp_r = 0, exp_l = 0, exp_r = 0;

  always #4 clk = ~clk;

  dc_block_hpf dut (
    .clk(clk), .rst(rst), .clear(clear), .in_valid(in_valid),
    .in_left(in_left), .in_right(in_right),
    .out_valid(out_valid), .out_left(out_left), .out_right(out_right));

  task automatic chk(input string req, input longint act, input longint expv);
    n_chk++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic longint clamp(input longint v);
    if (v > PMAX) return PMAX;
    if (v < NMIN) return NMIN;
    return v;
  endfunction

  // R4 reference recurrence
  task automatic model(input longint x, inout longint acc, inout longint xp, output longint y);
    acc = (x - xp) * 256 + acc - (acc >>> 13);
    xp  = x;
    y   = clamp(acc >>> 8);
  endtask

  task automatic model_clear();
    acc_l = 0; xp_l = 0; acc_r = 0; xp_r = 0;
  endtask

  task automatic send(input longint l, input longint r, input string req);
    @(negedge clk);
    in_valid = 1'b1;
    in_left  = 24'(l);
    in_right = 24'(r);
    model(l, acc_l, xp_l, exp_l);
    model(r, acc_r, xp_r, exp_r);
    @(negedge clk);
    in_valid = 1'b0;
    chk({req, " R2 out_valid"}, longint'(out_valid), 1);
    chk({req, " left"}, longint'(out_left), exp_l);
    chk({req, " right"}, longint'(out_right), exp_r);
  endtask

  task automatic do_clear();
    @(negedge clk);
    clear = 1'b1;
    @(negedge clk);
    clear = 1'b0;
    model_clear();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    chk("R1 out_valid in reset", longint'(out_valid), 0);
    chk("R1 left in reset", longint'(out_left), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 out_valid after reset", longint'(out_valid), 0);
    chk("R1 right after reset", longint'(out_right), 0);

    // R3 first pair after reset passes through; R4/R5 on the table
    send(longint'(TL[0]), longint'(TR[0]), "R3 first after reset");
    chk("R3 left equals input", longint'(out_left), longint'(TL[0]));
    for (int i = 1; i < NV; i++) send(longint'(TL[i]), longint'(TR[i]), "R4 R5 table");

    // R9 idle holds outputs and state; R2 single pulse
    begin
      longint hl, hr;
      hl = longint'(out_left);
      hr = longint'(out_right);
      in_left = 24'sd777777;
      in_right = -24'sd777777;
      repeat (5) @(negedge clk);
      chk("R2 out_valid low when idle", longint'(out_valid), 0);
      chk("R9 left held", longint'(out_left), hl);
      chk("R9 right held", longint'(out_right), hr);
    end
    send(12345, -54321, "R9 state held across idle");

    // R8 clear alone
    do_clear();
    chk("R8 left zero after clear", longint'(out_left), 0);
    chk("R8 out_valid low after clear", longint'(out_valid), 0);
    send(-9999, 4444, "R8 R3 first after clear");
    chk("R3 right equals input", longint'(out_right), 4444);

    // R8 clear overrides strobe
    @(negedge clk);
    clear = 1'b1; in_valid = 1'b1; in_left = 24'sd5000000; in_right = 24'sd5000000;
    @(negedge clk);
    clear = 1'b0; in_valid = 1'b0;
    model_clear();
    chk("R8 strobe dropped under clear", longint'(out_valid), 0);
    send(-300, 300, "R8 history empty after dropped strobe");
    chk("R8 left equals input", longint'(out_left), -300);

    // R5 channel independence
    do_clear();
    send(1000000, 0, "R5");
    send(-4000000, 0, "R5");
    send(2500000, 0, "R5");
    chk("R5 quiet right channel", longint'(out_right), 0);

    // R7 saturation both ways
    do_clear();
    send(NMIN, PMAX, "R7 load rails");
    send(PMAX, NMIN, "R7 rail swing");
    chk("R7 positive clamp", longint'(out_left), PMAX);
    chk("R7 negative clamp", longint'(out_right), NMIN);
    send(PMAX, NMIN, "R7 state not clamped");

    // R6 DC decay over 48000 back-to-back samples
    do_clear();
    @(negedge clk);
    in_valid = 1'b1;
    in_left = 24'(PMAX);
    in_right = 24'(NMIN);
    for (int k = 0; k < 48000; k++) begin
      model(PMAX, acc_l, xp_l, exp_l);
      model(NMIN, acc_r, xp_r, exp_r);
      @(negedge clk);
    end
    in_valid = 1'b0;
    chk("R6 left decay model", longint'(out_left), exp_l);
    chk("R6 right decay model", longint'(out_right), exp_r);
    chk("R6 left below bound", longint'(out_left < 24'sd131072 && out_left > -24'sd131072), 1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule